// File: doc/BRIEF.md
# E1 Receive Timeslot-0 Overhead Analyzer

This block sits behind an E1 receive synchronizer. For every received line bit it is given the bit itself, a valid flag and the bit's position: bit within the timeslot, timeslot within the frame, and frame within the 16-frame multiframe. It is also given two lock flags, one for basic frame alignment and one for multiframe alignment. From this it checks the timeslot-0 overhead. It counts frame alignment word errors, CRC-4 sub-multiframe mismatches and remote error indications (E bits) in three 8-bit counters. Each counter can be turned off on its own. A single-cycle strobe per counter copies the running count to that counter's status output and restarts the count.

It also follows the remote alarm (A) bit. It keeps an 8-deep history of the A bit, marks each complete group of eight A bits while only basic alignment is held, and flags the A-bit sequence 0,0,1. It stores the timeslot-0 byte of eight consecutive frames. It watches the raw line for an all-ones alarm signal (AIS) and for loss of signal. Position numbering: bit 0 is the first bit of a timeslot, and frame numbers run 0..15. Even frames carry the frame alignment word. Odd frames carry the non-alignment word.

Top module: `ovh_analyzer`

## Requirements
- R1: After reset, all three status counts, `a_hist`, `a_hist_rdy`, `a_pat_seen`, `ts0_bank`, `ais_det` and `los_det` are zero.
- R2: While `bf_locked` is 1, one alignment error is counted for each even frame whose timeslot-0 bits 1..7 differ from 0011011, and one for each odd frame whose timeslot-0 bit 1 is 0. While `bf_locked` is 0, no alignment error is counted.
- R3: While `mf_locked` is 1, one CRC-4 error is counted per sub-multiframe (frames 0-7 or 8-15) when that sub-multiframe's four C bits do not match the remainder of the preceding sub-multiframe. The C bits are bit 0 of the even frames, first received = x^3 term. The remainder uses generator x^4+x+1, is computed MSB-first, and treats the C-bit positions as 0. The first sub-multiframe after `mf_locked` rises is not checked.
- R4: While `mf_locked` is 1, each E bit (bit 0 of frames 13 and 15) received as 0 counts one E-bit error.
- R5: A sample strobe copies the running count to the status output and restarts the count at zero. Without a strobe, the status output holds its value.
- R6: A counter stops at 255 and does not wrap.
- R7: A counter whose off input is 1 does not advance.
- R8: While `bf_locked` is 1, each A bit (timeslot-0 bit 2 of odd frames) is shifted into `a_hist` at bit 0. The oldest A bit ends up in bit 7.
- R9: `a_hist_rdy` pulses for one cycle after every eighth A bit, counted from the time `bf_locked` last rose. It pulses only while `bf_locked` is 1 and `mf_locked` is 0.
- R10: `a_pat_seen` pulses for one cycle when the last three A bits, oldest first, are 0,0,1.
- R11: `ts0_bank[8k+7:8k]` holds the timeslot-0 byte of the last frame whose number mod 8 is k, with the first received bit as the MSB. All of `ts0_bank` reads 0 while `bf_locked` is 0.
- R12: Valid bits are grouped into windows of 512, counted from reset. At each window end, `ais_det` becomes 1 if the window held fewer than three zeros and 0 otherwise.
- R13: `los_det` is 1 once 255 consecutive valid zeros have been received, and clears on the next valid one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| bit_vld | input | 1 | a line bit is present this cycle |
| rx_bit | input | 1 | received line bit |
| ref_bit | input | 3 | bit position in timeslot, 0 first |
| ref_ts | input | 5 | timeslot number 0..31 |
| ref_frm | input | 4 | frame number in multiframe 0..15 |
| bf_locked | input | 1 | basic frame alignment held |
| mf_locked | input | 1 | multiframe alignment held |
| crc_cnt_off | input | 1 | stop the CRC-4 error counter |
| fas_cnt_off | input | 1 | stop the alignment error counter |
| ebit_cnt_off | input | 1 | stop the E-bit counter |
| crc_cnt_smp | input | 1 | sample and restart CRC-4 count |
| fas_cnt_smp | input | 1 | sample and restart alignment count |
| ebit_cnt_smp | input | 1 | sample and restart E-bit count |
| crc_err_cnt | output | 8 | sampled CRC-4 error count |
| fas_err_cnt | output | 8 | sampled alignment error count |
| ebit_err_cnt | output | 8 | sampled E-bit error count |
| a_hist | output | 8 | last eight A bits, newest in bit 0 |
| a_hist_rdy | output | 1 | eight A bits gathered |
| a_pat_seen | output | 1 | A-bit sequence 0,0,1 seen |
| ts0_bank | output | 64 | timeslot-0 bytes of eight frames |
| ais_det | output | 1 | all-ones alarm detected |
| los_det | output | 1 | loss of signal detected |

## Verification
A wrong remainder or C-bit register does not show up at once. It appears one to two sub-multiframes later, and only after a sample strobe, as a nonzero CRC-4 count on a clean stream. For this reason the bench follows every error campaign with a clean interval and samples it. A wrong A-bit group counter shows as a missing or extra `a_hist_rdy` pulse within eight odd frames. A window or run counter that is off by one shows only at the exact boundary: two versus three zeros, or 254 versus 255 zeros. Those boundaries are driven directly.

// File: rtl/ovh_pkg.sv
package ovh_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_CNT    = 3;
    localparam int SMF_FRAMES = 8;

    localparam logic [6:0] ALIGN_WORD = 7'b0011011;

    typedef enum logic [1:0] {
        CNT_CRC  = 2'd0,
        CNT_FAS  = 2'd1,
        CNT_EBIT = 2'd2
    } cnt_sel_e;

    typedef struct packed {
        logic [3:0] frm;
        logic [4:0] ts;
        logic [2:0] bt;
    } fpos_t;

    typedef struct packed {
        logic  vld;
        logic  data;
        fpos_t pos;
    } rx_beat_t;

    // one serial step of x^4 + x + 1, message bit enters at the top
    function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic d);
        logic fb;
        fb = c[3] ^ d;
        return {c[2:0], 1'b0} ^ {2'b00, fb, fb};
    endfunction

    function automatic logic in_ts0(input fpos_t p);
        return p.ts == 5'd0;
    endfunction

endpackage

// File: rtl/ovh_err_counter.sv
module ovh_err_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             off,
    input  logic             evt,
    input  logic             smp,
    output logic [CNT_W-1:0] status
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_q;
    logic             hit;

    assign hit = evt && !off;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            status <= '0;
        end else if (smp) begin
            status <= run_q;
            run_q  <= hit ? CNT_W'(1) : '0;
        end else if (hit && run_q != CNT_MAX) begin
            run_q <= run_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ovh_crc4_check.sv
module ovh_crc4_check
    import ovh_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rx_beat_t beat,
    input  logic     mf_locked,
    output logic     err_evt
);
    logic [3:0] crc_q, rem_q, cbits_q;
    logic       rem_vld_q;
    logic       smf_first, smf_last, cpos;
    logic [3:0] crc_nx, cbits_nx;

    assign smf_first = in_ts0(beat.pos) && beat.pos.bt == 3'd0 && beat.pos.frm[2:0] == 3'd0;
    assign smf_last  = beat.pos.ts == 5'd31 && beat.pos.bt == 3'd7 &&
                       beat.pos.frm[2:0] == 3'(SMF_FRAMES - 1);
    assign cpos      = in_ts0(beat.pos) && beat.pos.bt == 3'd0 && !beat.pos.frm[0];

    assign crc_nx   = crc4_step(smf_first ? 4'd0 : crc_q, cpos ? 1'b0 : beat.data);
    assign cbits_nx = cpos ? {cbits_q[2:0], beat.data} : cbits_q;

    assign err_evt = beat.vld && smf_last && mf_locked && rem_vld_q && (cbits_nx != rem_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q     <= '0;
            rem_q     <= '0;
            cbits_q   <= '0;
            rem_vld_q <= 1'b0;
        end else begin
            if (beat.vld) begin
                crc_q   <= crc_nx;
                cbits_q <= cbits_nx;
                if (smf_last) begin
                    rem_q     <= crc_nx;
                    rem_vld_q <= mf_locked;
                end
            end
            if (!mf_locked) rem_vld_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ovh_ts0_capture.sv
module ovh_ts0_capture
    import ovh_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  rx_beat_t                beat,
    input  logic                    bf_locked,
    input  logic                    mf_locked,
    output logic [BYTE_W-1:0]       ts0_byte,
    output logic                    ts0_last,
    output logic [BYTE_W*DEPTH-1:0] bank,
    output logic [BYTE_W-1:0]       hist,
    output logic                    hist_rdy,
    output logic                    pat_seen
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [BYTE_W-2:0] sr_q;
    logic [BYTE_W-1:0] bank_q [DEPTH];
    logic [2:0]        acnt_q;
    logic              a_tick;
    logic [BYTE_W-1:0] hist_nx;

    assign ts0_byte = {sr_q, beat.data};
    assign ts0_last = beat.vld && in_ts0(beat.pos) && beat.pos.bt == 3'd7;
    assign a_tick   = beat.vld && bf_locked && in_ts0(beat.pos) &&
                      beat.pos.bt == 3'd2 && beat.pos.frm[0];
    assign hist_nx  = {hist[BYTE_W-2:0], beat.data};

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else if (beat.vld && in_ts0(beat.pos)) sr_q <= ts0_byte[BYTE_W-2:0];
    end

    genvar k;
    generate
        for (k = 0; k < DEPTH; k++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) bank_q[k] <= '0;
                else if (ts0_last && beat.pos.frm[IDX_W-1:0] == IDX_W'(k)) bank_q[k] <= ts0_byte;
            end
            assign bank[BYTE_W*k +: BYTE_W] = bf_locked ? bank_q[k] : '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hist     <= '0;
            acnt_q   <= '0;
            hist_rdy <= 1'b0;
            pat_seen <= 1'b0;
        end else begin
            hist_rdy <= 1'b0;
            pat_seen <= 1'b0;
            if (!bf_locked) begin
                acnt_q <= '0;
            end else if (a_tick) begin
                hist     <= hist_nx;
                acnt_q   <= acnt_q + 3'd1;
                hist_rdy <= (acnt_q == 3'd7) && !mf_locked;
                pat_seen <= hist_nx[2:0] == 3'b001;
            end
        end
    end
endmodule

// File: rtl/ovh_line_alarm.sv
module ovh_line_alarm #(
    parameter int WIN      = 512,
    parameter int MAX_ZERO = 2,
    parameter int LOS_RUN  = 255
) (
    input  logic clk,
    input  logic rst,
    input  logic vld,
    input  logic data,
    output logic ais,
    output logic los
);
    localparam int WW = $clog2(WIN);
    localparam int ZW = $clog2(WIN + 1);
    localparam int RW = $clog2(LOS_RUN + 1);
    localparam logic [WW-1:0] W_LAST = WW'(WIN - 1);
    localparam logic [ZW-1:0] Z_MAX  = ZW'(MAX_ZERO);
    localparam logic [RW-1:0] R_END  = RW'(LOS_RUN);

    logic [WW-1:0] wcnt_q;
    logic [ZW-1:0] zc_q, zc_nx;
    logic [RW-1:0] run_q, run_nx;

    assign zc_nx  = ((wcnt_q == '0) ? '0 : zc_q) + ZW'(!data);
    assign run_nx = data ? '0 : ((run_q == R_END) ? run_q : run_q + RW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q <= '0;
            zc_q   <= '0;
            run_q  <= '0;
            ais    <= 1'b0;
            los    <= 1'b0;
        end else if (vld) begin
            wcnt_q <= (wcnt_q == W_LAST) ? '0 : wcnt_q + WW'(1);
            zc_q   <= zc_nx;
            if (wcnt_q == W_LAST) ais <= zc_nx <= Z_MAX;
            run_q  <= run_nx;
            los    <= run_nx == R_END;
        end
    end
endmodule

// File: rtl/ovh_analyzer.sv
module ovh_analyzer
    import ovh_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int BANK_DEPTH = 8,
    parameter int AIS_WIN    = 512,
    parameter int AIS_ZEROS  = 2,
    parameter int LOS_RUN    = 255
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bit_vld,
    input  logic                         rx_bit,
    input  logic [2:0]                   ref_bit,
    input  logic [4:0]                   ref_ts,
    input  logic [3:0]                   ref_frm,
    input  logic                         bf_locked,
    input  logic                         mf_locked,
    input  logic                         crc_cnt_off,
    input  logic                         fas_cnt_off,
    input  logic                         ebit_cnt_off,
    input  logic                         crc_cnt_smp,
    input  logic                         fas_cnt_smp,
    input  logic                         ebit_cnt_smp,
    output logic [CNT_W-1:0]             crc_err_cnt,
    output logic [CNT_W-1:0]             fas_err_cnt,
    output logic [CNT_W-1:0]             ebit_err_cnt,
    output logic [7:0]                   a_hist,
    output logic                         a_hist_rdy,
    output logic                         a_pat_seen,
    output logic [8*BANK_DEPTH-1:0]      ts0_bank,
    output logic                         ais_det,
    output logic                         los_det
);
    rx_beat_t          beat;
    logic [BYTE_W-1:0] ts0_byte;
    logic              ts0_last;
    logic              crc_evt, fas_evt, ebit_evt;
    logic [NUM_CNT-1:0] evt_v, off_v, smp_v;
    logic [CNT_W-1:0]  st_v [NUM_CNT];

    assign beat.vld     = bit_vld;
    assign beat.data    = rx_bit;
    assign beat.pos.frm = ref_frm;
    assign beat.pos.ts  = ref_ts;
    assign beat.pos.bt  = ref_bit;

    // alignment word check on even frames, fixed one on odd frames
    assign fas_evt = ts0_last && bf_locked &&
                     (ref_frm[0] ? !ts0_byte[6] : (ts0_byte[6:0] != ALIGN_WORD));

    assign ebit_evt = bit_vld && mf_locked && in_ts0(beat.pos) && ref_bit == 3'd0 &&
                      (ref_frm == 4'd13 || ref_frm == 4'd15) && !rx_bit;

    assign evt_v[CNT_CRC]  = crc_evt;
    assign evt_v[CNT_FAS]  = fas_evt;
    assign evt_v[CNT_EBIT] = ebit_evt;
    assign off_v[CNT_CRC]  = crc_cnt_off;
    assign off_v[CNT_FAS]  = fas_cnt_off;
    assign off_v[CNT_EBIT] = ebit_cnt_off;
    assign smp_v[CNT_CRC]  = crc_cnt_smp;
    assign smp_v[CNT_FAS]  = fas_cnt_smp;
    assign smp_v[CNT_EBIT] = ebit_cnt_smp;

    genvar i;
    generate
        for (i = 0; i < NUM_CNT; i++) begin : g_cnt
            ovh_err_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk    (clk),
                .rst    (rst),
                .off    (off_v[i]),
                .evt    (evt_v[i]),
                .smp    (smp_v[i]),
                .status (st_v[i])
            );
        end
    endgenerate

    assign crc_err_cnt  = st_v[CNT_CRC];
    assign fas_err_cnt  = st_v[CNT_FAS];
    assign ebit_err_cnt = st_v[CNT_EBIT];

    ovh_crc4_check u_crc (
        .clk       (clk),
        .rst       (rst),
        .beat      (beat),
        .mf_locked (mf_locked),
        .err_evt   (crc_evt)
    );

    ovh_ts0_capture #(.DEPTH(BANK_DEPTH)) u_ts0 (
        .clk       (clk),
        .rst       (rst),
        .beat      (beat),
        .bf_locked (bf_locked),
        .mf_locked (mf_locked),
        .ts0_byte  (ts0_byte),
        .ts0_last  (ts0_last),
        .bank      (ts0_bank),
        .hist      (a_hist),
        .hist_rdy  (a_hist_rdy),
        .pat_seen  (a_pat_seen)
    );

    ovh_line_alarm #(
        .WIN      (AIS_WIN),
        .MAX_ZERO (AIS_ZEROS),
        .LOS_RUN  (LOS_RUN)
    ) u_line (
        .clk  (clk),
        .rst  (rst),
        .vld  (bit_vld),
        .data (rx_bit),
        .ais  (ais_det),
        .los  (los_det)
    );
endmodule

// File: rtl/ovh_analyzer_chk.sv
module ovh_analyzer_chk #(
    parameter int CNT_W      = 8,
    parameter int BANK_DEPTH = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    bit_vld,
    input logic                    rx_bit,
    input logic                    bf_locked,
    input logic                    mf_locked,
    input logic                    crc_cnt_smp,
    input logic                    fas_cnt_smp,
    input logic                    ebit_cnt_smp,
    input logic [CNT_W-1:0]        crc_err_cnt,
    input logic [CNT_W-1:0]        fas_err_cnt,
    input logic [CNT_W-1:0]        ebit_err_cnt,
    input logic                    a_hist_rdy,
    input logic                    a_pat_seen,
    input logic [8*BANK_DEPTH-1:0] ts0_bank,
    input logic                    los_det
);
    // R5
    crc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !crc_cnt_smp |=> $stable(crc_err_cnt));
    // R5
    fas_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fas_cnt_smp |=> $stable(fas_err_cnt));
    // R5
    ebit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ebit_cnt_smp |=> $stable(ebit_err_cnt));
    // R9
    hist_rdy_gate_chk: assert property (@(posedge clk) disable iff (rst)
        a_hist_rdy |-> $past(bf_locked && !mf_locked));
    // R10
    pat_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        a_pat_seen |=> !a_pat_seen);
    // R11
    bank_mute_chk: assert property (@(posedge clk) disable iff (rst)
        !bf_locked |-> ts0_bank == '0);
    // R13
    los_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(los_det) |-> $past(bit_vld && !rx_bit));
endmodule

bind ovh_analyzer ovh_analyzer_chk #(.CNT_W(CNT_W), .BANK_DEPTH(BANK_DEPTH)) u_chk (.*);

// File: tb/ovh_analyzer_test.sv
module ovh_analyzer_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_vld = 1'b0, rx_bit = 1'b0;
    logic [2:0] ref_bit = '0;
    logic [4:0] ref_ts = '0;
    logic [3:0] ref_frm = '0;
    logic bf_locked = 1'b0, mf_locked = 1'b0;
    logic crc_cnt_off = 1'b0, fas_cnt_off = 1'b0, ebit_cnt_off = 1'b0;
    logic crc_cnt_smp = 1'b0, fas_cnt_smp = 1'b0, ebit_cnt_smp = 1'b0;
    logic [7:0] crc_err_cnt, fas_err_cnt, ebit_err_cnt, a_hist;
    logic a_hist_rdy, a_pat_seen, ais_det, los_det;
    logic [63:0] ts0_bank;

    ovh_analyzer uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_err = 0;
    int rdy_seen = 0, pat_seen = 0;
    bit done = 0;

    // stream generator state
    int p_frm = 0, p_ts = 0, p_bt = 0;
    int nbits = 0;
    logic [3:0] b_crc = '0, prev_rem = '0;
    logic [7:0] cur_byte = '0;
    logic [7:0] sent_ts0 [8];
    logic [15:0] lfsr = 16'hACE1;
    logic fas_bad = 0, nfas_bad = 0, c_bad = 0, ebit_val = 1, a_val = 0;

    always @(negedge clk) if (!rst) begin
        rdy_seen += int'(a_hist_rdy);
        pat_seen += int'(a_pat_seen);
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ov: -1 generated content, 0 or 1 forced line bit
    task automatic send_bit(input int ov);
        logic b, cd;
        logic [5:0] mfas;
        logic [6:0] aw;
        mfas = 6'b001011;
        aw = 7'b0011011;
        if (p_ts == 0) begin
            if (p_bt == 0) begin
                if (p_frm % 2 == 0) b = prev_rem[3 - (p_frm % 8) / 2] ^ (c_bad && (p_frm % 8) == 0);
                else if (p_frm == 13 || p_frm == 15) b = ebit_val;
                else b = mfas[5 - p_frm / 2];
            end else if (p_frm % 2 == 0) begin
                b = aw[7 - p_bt] ^ (fas_bad && p_bt == 1);
            end else begin
                b = (p_bt == 1) ? !nfas_bad : (p_bt == 2) ? a_val : 1'b1;
            end
        end else begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b = lfsr[0];
        end
        if (ov >= 0) b = ov[0];
        cd = (p_ts == 0 && p_bt == 0 && p_frm % 2 == 0) ? 1'b0 : b;
        if (p_ts == 0 && p_bt == 0 && p_frm % 8 == 0) b_crc = '0;
        b_crc = {b_crc[2:0], 1'b0} ^ {2'b00, b_crc[3] ^ cd, b_crc[3] ^ cd};
        if (p_ts == 31 && p_bt == 7 && p_frm % 8 == 7) prev_rem = b_crc;
        if (p_ts == 0) begin
            cur_byte[7 - p_bt] = b;
            if (p_bt == 7) sent_ts0[p_frm % 8] = cur_byte;
        end
        @(negedge clk);
        bit_vld = 1'b1;
        rx_bit  = b;
        ref_bit = 3'(p_bt);
        ref_ts  = 5'(p_ts);
        ref_frm = 4'(p_frm);
        nbits++;
        p_bt++;
        if (p_bt == 8) begin p_bt = 0; p_ts++; end
        if (p_ts == 32) begin p_ts = 0; p_frm = (p_frm + 1) % 16; end
    endtask

    task automatic send_frames(input int n);
        for (int f = 0; f < n; f++)
            for (int j = 0; j < 256; j++) send_bit(-1);
    endtask

    task automatic idle_edge();
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic align_mf();
        while (p_frm != 0) send_frames(1);
    endtask

    task automatic sample_all();
        @(negedge clk);
        bit_vld = 1'b0;
        {crc_cnt_smp, fas_cnt_smp, ebit_cnt_smp} = 3'b111;
        @(negedge clk);
        {crc_cnt_smp, fas_cnt_smp, ebit_cnt_smp} = 3'b000;
    endtask

    task automatic t_reset();
        chk("R1 crc count", crc_err_cnt, 0);
        chk("R1 fas count", fas_err_cnt, 0);
        chk("R1 ebit count", ebit_err_cnt, 0);
        chk("R1 hist", {a_hist, a_hist_rdy, a_pat_seen}, 0);
        chk("R1 bank", ts0_bank, 0);
        chk("R1 alarms", {ais_det, los_det}, 0);
    endtask

    task automatic t_unlocked();
        fas_bad = 1; nfas_bad = 1;
        send_frames(2);
        fas_bad = 0; nfas_bad = 0;
        sample_all();
        chk("R2 unlocked ignored", fas_err_cnt, 0);
        chk("R11 bank muted", ts0_bank, 0);
    endtask

    task automatic t_fas();
        bf_locked = 1;
        sample_all();
        fas_bad = 1; send_frames(4); fas_bad = 0;
        nfas_bad = 1; send_frames(2); nfas_bad = 0;
        sample_all();
        chk("R2 align errors", fas_err_cnt, 3);
        send_frames(2);
        idle_edge();
        chk("R5 status holds", fas_err_cnt, 3);
        sample_all();
        chk("R5 restart", fas_err_cnt, 0);
    endtask

    task automatic t_abits();
        logic [7:0] seq;
        int k, r0, p0;
        seq = 8'b00101101;
        @(negedge clk); bit_vld = 0; bf_locked = 0;
        @(negedge clk); bf_locked = 1;
        r0 = rdy_seen; p0 = pat_seen; k = 0;
        while (k < 8) begin
            if (p_frm % 2 == 1) begin a_val = seq[7 - k]; k++; end
            send_frames(1);
        end
        idle_edge();
        chk("R8 history", a_hist, 8'h2D);
        chk("R9 ready pulse", rdy_seen - r0, 1);
        chk("R10 pattern pulse", pat_seen - p0, 1);
        @(negedge clk); bf_locked = 0;
        @(negedge clk); bf_locked = 1; mf_locked = 1;
        r0 = rdy_seen; p0 = pat_seen; k = 0; a_val = 1;
        while (k < 8) begin
            if (p_frm % 2 == 1) k++;
            send_frames(1);
        end
        idle_edge();
        chk("R9 no pulse in multiframe lock", rdy_seen - r0, 0);
        chk("R8 history ones", a_hist, 8'hFF);
        chk("R10 no pattern", pat_seen - p0, 0);
        a_val = 0; mf_locked = 0;
    endtask

    task automatic t_bank();
        logic [63:0] exp;
        align_mf();
        send_frames(8);
        idle_edge();
        for (int k = 0; k < 8; k++) exp[8*k +: 8] = sent_ts0[k];
        chk("R11 bank content", ts0_bank, exp);
        @(negedge clk); bf_locked = 0;
        #1 chk("R11 bank zero when unlocked", ts0_bank, 0);
        @(negedge clk); bf_locked = 1;
    endtask

    task automatic t_crc_ebit();
        align_mf();
        mf_locked = 1;
        sample_all();
        send_frames(16);
        sample_all();
        chk("R3 clean stream", crc_err_cnt, 0);
        chk("R4 clean E bits", ebit_err_cnt, 0);
        c_bad = 1; ebit_val = 0;
        send_frames(16);
        c_bad = 0; ebit_val = 1;
        sample_all();
        chk("R3 two bad sub-multiframes", crc_err_cnt, 2);
        chk("R4 two E errors", ebit_err_cnt, 2);
        chk("R2 no align errors", fas_err_cnt, 0);
        send_frames(16);
        sample_all();
        chk("R3 recovered", crc_err_cnt, 0);
    endtask

    task automatic t_disable();
        {crc_cnt_off, fas_cnt_off, ebit_cnt_off} = 3'b111;
        c_bad = 1; ebit_val = 0; fas_bad = 1;
        send_frames(16);
        c_bad = 0; ebit_val = 1; fas_bad = 0;
        sample_all();
        chk("R7 crc off", crc_err_cnt, 0);
        chk("R7 fas off", fas_err_cnt, 0);
        chk("R7 ebit off", ebit_err_cnt, 0);
        {crc_cnt_off, fas_cnt_off, ebit_cnt_off} = 3'b000;
        mf_locked = 0;
    endtask

    task automatic t_saturate();
        sample_all();
        fas_bad = 1; nfas_bad = 1;
        send_frames(258);
        fas_bad = 0; nfas_bad = 0;
        sample_all();
        chk("R6 saturation", fas_err_cnt, 255);
    endtask

    task automatic send_window(input int zeros, input bit gen);
        while (nbits % 512 != 0) send_bit(1);
        for (int j = 0; j < 512; j++) send_bit(gen ? -1 : (j < zeros ? 0 : 1));
        idle_edge();
    endtask

    task automatic t_line();
        bf_locked = 0;
        send_window(0, 1);
        chk("R12 normal data", ais_det, 0);
        send_window(2, 0);
        chk("R12 two zeros", ais_det, 1);
        send_window(3, 0);
        chk("R12 three zeros", ais_det, 0);
        send_bit(1);
        for (int j = 0; j < 254; j++) send_bit(0);
        idle_edge();
        chk("R13 254 zeros", los_det, 0);
        send_bit(0);
        idle_edge();
        chk("R13 255 zeros", los_det, 1);
        send_bit(1);
        idle_edge();
        chk("R13 cleared by one", los_det, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_unlocked();
        t_fas();
        t_abits();
        t_bank();
        t_crc_ebit();
        t_disable();
        t_saturate();
        t_line();
        finish_run();
    end
endmodule